// File: doc/BRIEF.md
# Debug Run-Control Register Bank

This block is a bank of 28 addressable 32-bit registers that sits behind a debug access port. A debug host writes and reads the registers through a flat address/data interface. One register at a fixed address is the processor run-control word. Its low two bits drive the core's stall and reset lines. Clearing the reset bit after it was set produces a single-cycle system-reset pulse. All the other registers only store what is written to them and return it on reads.

The block also has an in-reset status for the breakpoint logic, which keeps that logic quiet while the core is held in reset. An external stall request, such as one from exception trapping, sets the stall bit so the host can see it. A next-PC-invalid flag is set by the core side and is cleared when the host releases the stall.

Top module: `dbg_ctl_bank`

## Requirements
- R1: A write (acc_we high at a clock edge) to an address from 0 to 27 stores the 32-bit data. While acc_re is high with such an address, acc_rdata shows the stored value combinationally and acc_err is low. Reads change nothing. When acc_re is low, acc_rdata is zero.
- R2: Any access with an address of 28 to 31 raises acc_err combinationally in the same cycle. A write to such an address changes no register and no output, and a read of it returns zero.
- R3: The run-control register is at address 4. From the edge that completes a write to it, core_stall equals bit 0 of that register. core_reset and in_reset both equal bit 1.
- R4: sys_rst_pulse is high for exactly the one cycle after a write to address 4 that clears bit 1 while bit 1 was set. Rewriting bit 1 as 1 gives no pulse. A 0-to-0 write gives no pulse, a 0-to-1 write gives no pulse, and a write to any other address gives no pulse.
- R5: When ext_stall_req is high at a clock edge, bit 0 of the run-control register becomes 1 and core_stall rises. This holds even if the same edge writes 0 to that bit.
- R6: npc_invalid is set by npc_mark. It is cleared by a write to address 4 that leaves bit 0 at 0. If both happen at the same edge, the clear wins. A write that leaves the stall bit set does not clear it.
- R7: With rst_n low, all 28 registers read zero, and core_stall, core_reset, in_reset, sys_rst_pulse and npc_invalid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low debug-unit reset |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_we | input | 1 | Write enable |
| acc_re | input | 1 | Read strobe |
| acc_rdata | output | 32 | Read data, zero when not reading |
| acc_err | output | 1 | Invalid-address flag |
| ext_stall_req | input | 1 | External request to set the stall bit |
| npc_mark | input | 1 | Sets the next-PC-invalid flag |
| core_stall | output | 1 | Stall to the core |
| core_reset | output | 1 | Reset level to the core |
| in_reset | output | 1 | Breakpoint suppression status |
| sys_rst_pulse | output | 1 | One-cycle system-reset pulse |
| npc_invalid | output | 1 | Next-PC-invalid flag |

## Verification
The hardest condition to reach is the reset pulse, because it depends on the history of two writes and not on any one access. The stimulus steps the run-control word through every old/new pairing of bit 1. It also puts writes to other addresses and to invalid addresses between the set and the clear, then checks the pulse on the cycle right after each write and again one cycle later. Conflicts where two sources act at the same edge are forced on purpose: an external stall meeting a write of zero, and a flag set meeting a stall release.

// File: rtl/dbg_ctl_bank.sv
module dbg_ctl_bank #(
  parameter int NREGS     = 28,
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int RC_ADDR   = 4,
  parameter int STALL_BIT = 0,
  parameter int RST_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          acc_we,
  input  logic          acc_re,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_err,
  input  logic          ext_stall_req,
  input  logic          npc_mark,
  output logic          core_stall,
  output logic          core_reset,
  output logic          in_reset,
  output logic          sys_rst_pulse,
  output logic          npc_invalid
);

  localparam logic [AW:0]   LIMIT = (AW+1)'(NREGS);
  localparam logic [AW-1:0] RCA   = AW'(RC_ADDR);

  logic [DW-1:0] bank [0:NREGS-1];
  logic          addr_ok, wr_hit, rc_wr;
  logic [DW-1:0] rc_next;

  assign addr_ok = {1'b0, acc_addr} < LIMIT;
  assign wr_hit  = acc_we & addr_ok;
  assign rc_wr   = wr_hit & (acc_addr == RCA);

  always_comb begin
    rc_next = rc_wr ? acc_wdata : bank[RC_ADDR];
    if (ext_stall_req) rc_next[STALL_BIT] = 1'b1;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == RC_ADDR) begin : g_rc
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) bank[i] <= '0;
        else        bank[i] <= rc_next;
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                               bank[i] <= '0;
        else if (wr_hit && acc_addr == AW'(i))    bank[i] <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sys_rst_pulse <= 1'b0;
    else        sys_rst_pulse <= rc_wr & bank[RC_ADDR][RST_BIT] & ~acc_wdata[RST_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             npc_invalid <= 1'b0;
    else if (rc_wr && !rc_next[STALL_BIT])  npc_invalid <= 1'b0;
    else if (npc_mark)                      npc_invalid <= 1'b1;

  assign core_stall = bank[RC_ADDR][STALL_BIT];
  assign core_reset = bank[RC_ADDR][RST_BIT];
  assign in_reset   = bank[RC_ADDR][RST_BIT];
  assign acc_err    = (acc_we | acc_re) & ~addr_ok;
  assign acc_rdata  = (acc_re && addr_ok) ? bank[acc_addr] : '0;

  a_r4_pulse_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);

  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> $past(in_reset) && !in_reset);

  a_r3_stall_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == RCA) |=> core_stall == $past(acc_wdata[STALL_BIT] | ext_stall_req));

  a_r2_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_err && !ext_stall_req) |=> $stable(core_stall) && $stable(in_reset) && !sys_rst_pulse);

  a_r6_npc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == RCA && !acc_wdata[STALL_BIT] && !ext_stall_req) |=> !npc_invalid);

  a_r5_ext_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ext_stall_req |=> core_stall);

endmodule

// File: tb/test_dbg_ctl_bank.sv
module test_dbg_ctl_bank;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_we = 0, acc_re = 0, ext_stall_req = 0, npc_mark = 0;
  logic [31:0] acc_rdata;
  logic        acc_err, core_stall, core_reset, in_reset, sys_rst_pulse, npc_invalid;
  int checks = 0, errors = 0;
  logic [31:0] rd_v;
  logic        rd_e, wr_e;

  always #5 clk = ~clk;

  dbg_ctl_bank i_dbg_ctl_bank (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_we = 1;
    #1 wr_e = acc_err;
    @(negedge clk);
    acc_we = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    acc_addr = a; acc_re = 1;
    #1 rd_v = acc_rdata; rd_e = acc_err;
    acc_re = 0;
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h9E370000 + 32'(a) * 32'h00000111;
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R7 reset state
    ceq("R7 stall", core_stall, 0); ceq("R7 reset", core_reset, 0);
    ceq("R7 in_reset", in_reset, 0); ceq("R7 pulse", sys_rst_pulse, 0);
    ceq("R7 npc", npc_invalid, 0);
    rst_n = 1;
    for (int a = 0; a < 28; a++) begin rd(5'(a)); ceq("R7 zero", rd_v, 0); end

    // R1/R2 sweep over every address
    for (int a = 0; a < 32; a++) begin
      wr(5'(a), pat(a));
      ceq("R2 write err", 32'(wr_e), 32'(a >= 28));
      ceq("R4 no pulse on sweep", sys_rst_pulse, 0);
    end
    for (int a = 0; a < 32; a++) begin
      rd(5'(a));
      ceq("R1 R2 read data", rd_v, a < 28 ? pat(a) : 32'h0);
      ceq("R2 read err", 32'(rd_e), 32'(a >= 28));
    end
    @(negedge clk); acc_addr = 5'd3; #1 ceq("R1 idle rdata", acc_rdata, 0);
    rd(5'd3); ceq("R1 reread no side effect", rd_v, pat(3));

    // R3 / R4 run-control walk
    wr(5'd4, 32'h1);
    ceq("R3 stall", core_stall, 1); ceq("R3 reset", core_reset, 0);
    ceq("R4 0->0", sys_rst_pulse, 0);
    wr(5'd4, 32'h3);
    ceq("R3 in_reset", in_reset, 1); ceq("R3 core_reset", core_reset, 1);
    ceq("R4 0->1", sys_rst_pulse, 0);
    wr(5'd4, 32'h3); ceq("R4 1->1", sys_rst_pulse, 0);
    wr(5'd9, 32'h0); ceq("R4 other addr", sys_rst_pulse, 0);
    ceq("R3 in_reset kept", in_reset, 1);
    wr(5'd30, 32'h0); ceq("R2 bad write err", 32'(wr_e), 1);
    ceq("R2 in_reset kept", in_reset, 1); ceq("R2 stall kept", core_stall, 1);
    wr(5'd4, 32'h0);
    ceq("R4 1->0 pulse", sys_rst_pulse, 1);
    ceq("R3 released", in_reset, 0); ceq("R3 stall off", core_stall, 0);
    @(negedge clk); ceq("R4 pulse one wide", sys_rst_pulse, 0);
    wr(5'd4, 32'h2); ceq("R4 set no pulse", sys_rst_pulse, 0);
    wr(5'd4, 32'hFFFF_FFFC);
    ceq("R4 second pulse", sys_rst_pulse, 1);
    rd(5'd4); ceq("R1 rc readback", rd_v, 32'hFFFF_FFFC);
    @(negedge clk); ceq("R4 pulse ends", sys_rst_pulse, 0);

    // R5 external stall
    wr(5'd4, 32'h0);
    @(negedge clk); ext_stall_req = 1;
    @(negedge clk); ext_stall_req = 0;
    ceq("R5 stall set", core_stall, 1);
    rd(5'd4); ceq("R5 readback", rd_v, 32'h1);
    @(negedge clk); acc_addr = 5'd4; acc_wdata = 32'h0; acc_we = 1; ext_stall_req = 1;
    @(negedge clk); acc_we = 0; ext_stall_req = 0;
    ceq("R5 overrides write", core_stall, 1);
    wr(5'd4, 32'h0); ceq("R5 release", core_stall, 0);

    // R6 next-PC-invalid flag
    @(negedge clk); npc_mark = 1;
    @(negedge clk); npc_mark = 0;
    ceq("R6 set", npc_invalid, 1);
    wr(5'd6, 32'h0); ceq("R6 other addr keeps", npc_invalid, 1);
    wr(5'd4, 32'h1); ceq("R6 stall write keeps", npc_invalid, 1);
    wr(5'd4, 32'h0); ceq("R6 cleared", npc_invalid, 0);
    @(negedge clk); acc_addr = 5'd4; acc_wdata = 32'h0; acc_we = 1; npc_mark = 1;
    @(negedge clk); acc_we = 0; npc_mark = 0;
    ceq("R6 clear wins", npc_invalid, 0);

    // R7 reset mid-run
    wr(5'd4, 32'h3); wr(5'd12, 32'hDEAD_BEEF);
    @(negedge clk); npc_mark = 1; @(negedge clk); npc_mark = 0;
    rst_n = 0; #1;
    ceq("R7 mid stall", core_stall, 0); ceq("R7 mid in_reset", in_reset, 0);
    ceq("R7 mid npc", npc_invalid, 0);
    @(negedge clk); rst_n = 1;
    rd(5'd12); ceq("R7 mid reg cleared", rd_v, 0);
    rd(5'd4);  ceq("R7 mid rc cleared", rd_v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule